// File: doc/BRIEF.md
# Error Status and Reporting Unit

This unit keeps the error status of one PCI Express function. Error detectors elsewhere in the port raise one-cycle event pulses on a correctable event vector and an uncorrectable event vector. Each event sets a sticky status bit at a fixed position. Three enable masks choose whether a newly set bit raises a correctable, a non-fatal or a fatal report request. These requests are one-cycle pulses for the message generator. An uncorrectable event may also carry the four-doubleword header of the TLP that caused it. The first such header is held in a log until software clears the uncorrectable status.

Software reads the status through a small read port. A status read returns the bits gathered so far and clears them in the same access. The header log is read one doubleword at a time. Read data is registered and appears one cycle after the request.

Top module: `aer_err_log`

## Requirements
- R1: Correctable events set status bits only at positions 0, 6, 7, 8, 12, 13 and 14.
- R2: Uncorrectable events set status bits only at positions 4, 12 to 20, 22 and 24.
- R3: Any other bit position in either status vector never sets and always reads as zero.
- R4: Status bits are sticky. Each one stays set until it is cleared by a read, and it is set whether or not its enable bit is set.
- R5: A read with `rd_sel`=0 returns the correctable status and a read with `rd_sel`=1 returns the uncorrectable status. The value is on `rd_data` in the cycle after `rd_en`, and that vector is cleared by the same access.
- R6: When an event arrives in the same cycle as the clearing read of its vector, the event bit is kept after the clear. A header that arrives with such an uncorrectable event is captured.
- R7: `rpt_corr` pulses for one cycle, one cycle after a correctable event sets a bit that was clear and whose `corr_en` bit is set. An event on a bit that is already set gives no pulse.
- R8: An uncorrectable bit that is newly set and enabled in `fatal_en` pulses `rpt_fatal`. Such a bit never pulses `rpt_nonfatal`, even when it is also enabled in `nonfatal_en`. A newly set bit enabled only in `nonfatal_en` pulses `rpt_nonfatal`.
- R9: A zero enable mask, or a clear enable bit, suppresses reporting for that bit.
- R10: The header log captures `unc_hdr` on the first uncorrectable event that has `unc_hdr_vld` set. It then stays frozen, and later headers are ignored. It reads as zero after reset.
- R11: Clearing the uncorrectable status releases the log, so the next uncorrectable event that carries a header is captured.
- R12: `rd_sel` values 4 to 7 return header doublewords 0 to 3, where doubleword 0 is `unc_hdr[31:0]`. Values 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_evt | input | 32 | Correctable error event pulses, one bit per position |
| unc_evt | input | 32 | Uncorrectable error event pulses |
| unc_hdr_vld | input | 1 | The uncorrectable event this cycle carries a header |
| unc_hdr | input | 128 | Header of the offending TLP, four doublewords |
| corr_en | input | 32 | Correctable reporting enable mask |
| nonfatal_en | input | 32 | Uncorrectable non-fatal reporting enable mask |
| fatal_en | input | 32 | Uncorrectable fatal reporting enable mask |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Read target select |
| rd_data | output | 32 | Registered read data |
| rpt_corr | output | 1 | Correctable report request pulse |
| rpt_nonfatal | output | 1 | Non-fatal report request pulse |
| rpt_fatal | output | 1 | Fatal report request pulse |

## Verification
The assertions assume that `rst` is held for at least one clock before checking starts. They also assume that the enable masks change only between events and not in the cycle an event arrives. The stimulus keeps to both: it changes masks on falling edges and only while no event pulse is being driven. It drives each event for exactly one cycle and issues one read at a time. The stimulus also sets events on undefined positions and reuses bits that are already set. It places events in the same cycle as a clearing read, and it sends headers while the log is frozen.

// File: rtl/aer_pkg.sv
package aer_pkg;
  localparam int STAT_W = 32;

  // correctable status positions
  localparam int C_RXERR   = 0;
  localparam int C_BADTLP  = 6;
  localparam int C_BADDLLP = 7;
  localparam int C_RPLYROL = 8;
  localparam int C_RPLYTMO = 12;
  localparam int C_ADVNF   = 13;
  localparam int C_INTERR  = 14;

  // uncorrectable status positions
  localparam int U_DLPE    = 4;
  localparam int U_POISON  = 12;
  localparam int U_FCPE    = 13;
  localparam int U_CPLTO   = 14;
  localparam int U_CPLABT  = 15;
  localparam int U_UNXCPL  = 16;
  localparam int U_RXOVF   = 17;
  localparam int U_MALF    = 18;
  localparam int U_ECRC    = 19;
  localparam int U_UNSUP   = 20;
  localparam int U_INTERR  = 22;
  localparam int U_ATOMBLK = 24;

  localparam logic [STAT_W-1:0] CORR_IMPL =
      (STAT_W'(1) << C_RXERR)   | (STAT_W'(1) << C_BADTLP) |
      (STAT_W'(1) << C_BADDLLP) | (STAT_W'(1) << C_RPLYROL) |
      (STAT_W'(1) << C_RPLYTMO) | (STAT_W'(1) << C_ADVNF) |
      (STAT_W'(1) << C_INTERR);

  localparam logic [STAT_W-1:0] UNC_IMPL =
      (STAT_W'(1) << U_DLPE)   | (STAT_W'(1) << U_POISON) |
      (STAT_W'(1) << U_FCPE)   | (STAT_W'(1) << U_CPLTO) |
      (STAT_W'(1) << U_CPLABT) | (STAT_W'(1) << U_UNXCPL) |
      (STAT_W'(1) << U_RXOVF)  | (STAT_W'(1) << U_MALF) |
      (STAT_W'(1) << U_ECRC)   | (STAT_W'(1) << U_UNSUP) |
      (STAT_W'(1) << U_INTERR) | (STAT_W'(1) << U_ATOMBLK);

  // read select codes
  localparam logic [2:0] SEL_CORR = 3'd0;
  localparam logic [2:0] SEL_UNC  = 3'd1;
endpackage

// File: rtl/aer_stat_reg.sv
module aer_stat_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] new_bits
);
  logic [W-1:0] evt_m;

  assign evt_m    = evt & IMPL;
  assign new_bits = evt_m & ~stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (clr ? '0 : stat_q) | evt_m;
  end

  // R3
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~IMPL) == '0);

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6
  clr_keep_evt_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stat_q == ($past(evt) & IMPL)));
endmodule

// File: rtl/aer_report.sv
module aer_report #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] corr_new,
  input  logic [W-1:0] unc_new,
  input  logic [W-1:0] corr_en,
  input  logic [W-1:0] nonfatal_en,
  input  logic [W-1:0] fatal_en,
  output logic         rpt_corr,
  output logic         rpt_nonfatal,
  output logic         rpt_fatal
);
  logic [W-1:0] fat_bits, nf_bits;

  // fatal routing wins per bit
  assign fat_bits = unc_new & fatal_en;
  assign nf_bits  = unc_new & nonfatal_en & ~fatal_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rpt_corr     <= 1'b0;
      rpt_nonfatal <= 1'b0;
      rpt_fatal    <= 1'b0;
    end else begin
      rpt_corr     <= |(corr_new & corr_en);
      rpt_nonfatal <= |nf_bits;
      rpt_fatal    <= |fat_bits;
    end
  end

  // R9
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (corr_en == '0) |=> !rpt_corr);

  // R8
  no_nf_when_only_fatal_chk: assert property (@(posedge clk) disable iff (rst)
    ((unc_new & nonfatal_en & ~fatal_en) == '0) |=> !rpt_nonfatal);
endmodule

// File: rtl/aer_hdr_log.sv
module aer_hdr_log #(
  parameter int DW_W   = 32,
  parameter int HDR_DW = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hdr_evt,
  input  logic                         clr,
  input  logic [HDR_DW*DW_W-1:0]       hdr_in,
  output logic [HDR_DW-1:0][DW_W-1:0]  log_q,
  output logic                         frozen
);
  logic cap;

  assign cap = hdr_evt && (!frozen || clr);

  genvar g;
  generate
    for (g = 0; g < HDR_DW; g++) begin : g_dw
      always_ff @(posedge clk) begin
        if (rst)      log_q[g] <= '0;
        else if (cap) log_q[g] <= hdr_in[g*DW_W +: DW_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      frozen <= 1'b0;
    else if (cap) frozen <= 1'b1;
    else if (clr) frozen <= 1'b0;
  end

  // R10
  frozen_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen && !clr) |=> $stable(log_q));
endmodule

// File: rtl/aer_err_log.sv
module aer_err_log
  import aer_pkg::*;
#(
  parameter int DW_W   = 32,
  parameter int HDR_DW = 4,
  parameter int SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [STAT_W-1:0]      corr_evt,
  input  logic [STAT_W-1:0]      unc_evt,
  input  logic                   unc_hdr_vld,
  input  logic [HDR_DW*DW_W-1:0] unc_hdr,
  input  logic [STAT_W-1:0]      corr_en,
  input  logic [STAT_W-1:0]      nonfatal_en,
  input  logic [STAT_W-1:0]      fatal_en,
  input  logic                   rd_en,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [DW_W-1:0]        rd_data,
  output logic                   rpt_corr,
  output logic                   rpt_nonfatal,
  output logic                   rpt_fatal
);
  localparam int IDX_W = $clog2(HDR_DW);

  logic [STAT_W-1:0] corr_q, unc_q, corr_new, unc_new;
  logic [HDR_DW-1:0][DW_W-1:0] log_q;
  logic clr_corr, clr_unc, hdr_evt, frozen;
  logic [DW_W-1:0] rd_mux;

  assign clr_corr = rd_en && (rd_sel == SEL_W'(SEL_CORR));
  assign clr_unc  = rd_en && (rd_sel == SEL_W'(SEL_UNC));
  assign hdr_evt  = unc_hdr_vld && ((unc_evt & UNC_IMPL) != '0);

  aer_stat_reg #(.W(STAT_W), .IMPL(CORR_IMPL)) u_corr (
    .clk(clk), .rst(rst), .evt(corr_evt), .clr(clr_corr),
    .stat_q(corr_q), .new_bits(corr_new));

  aer_stat_reg #(.W(STAT_W), .IMPL(UNC_IMPL)) u_unc (
    .clk(clk), .rst(rst), .evt(unc_evt), .clr(clr_unc),
    .stat_q(unc_q), .new_bits(unc_new));

  aer_report #(.W(STAT_W)) u_rpt (
    .clk(clk), .rst(rst), .corr_new(corr_new), .unc_new(unc_new),
    .corr_en(corr_en), .nonfatal_en(nonfatal_en), .fatal_en(fatal_en),
    .rpt_corr(rpt_corr), .rpt_nonfatal(rpt_nonfatal), .rpt_fatal(rpt_fatal));

  aer_hdr_log #(.DW_W(DW_W), .HDR_DW(HDR_DW)) u_log (
    .clk(clk), .rst(rst), .hdr_evt(hdr_evt), .clr(clr_unc),
    .hdr_in(unc_hdr), .log_q(log_q), .frozen(frozen));

  always_comb begin
    rd_mux = '0;
    if (rd_sel[SEL_W-1])
      rd_mux = log_q[rd_sel[IDX_W-1:0]];
    else if (rd_sel == SEL_W'(SEL_CORR))
      rd_mux = DW_W'(corr_q);
    else if (rd_sel == SEL_W'(SEL_UNC))
      rd_mux = DW_W'(unc_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R7
  corr_pulse_has_status_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_corr |-> (corr_q != '0));

  // R8
  fatal_pulse_has_status_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_fatal |-> (unc_q != '0));

  // R5
  corr_read_value_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_W'(SEL_CORR)) |=> (rd_data == DW_W'($past(corr_q))));

  // R11
  log_release_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_unc && !hdr_evt) |=> !frozen);
endmodule

// File: tb/sim_aer_err_log.sv
module sim_aer_err_log;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] corr_evt = '0, unc_evt = '0;
  logic unc_hdr_vld = 1'b0;
  logic [127:0] unc_hdr = '0;
  logic [31:0] corr_en = '1, nonfatal_en = '0, fatal_en = '0;
  logic rd_en = 1'b0;
  logic [2:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic rpt_corr, rpt_nonfatal, rpt_fatal;

  int n_cmp = 0, n_bad = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aer_err_log u0 (
    .clk(clk), .rst(rst), .corr_evt(corr_evt), .unc_evt(unc_evt),
    .unc_hdr_vld(unc_hdr_vld), .unc_hdr(unc_hdr), .corr_en(corr_en),
    .nonfatal_en(nonfatal_en), .fatal_en(fatal_en), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .rpt_corr(rpt_corr),
    .rpt_nonfatal(rpt_nonfatal), .rpt_fatal(rpt_fatal));

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: pops expected read data
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s rd_data act=%h exp=%h", t, rd_data, e);
      end
    end
  end

  task automatic step(input logic [31:0] c, input logic [31:0] u,
                      input logic hv, input logic [127:0] h,
                      input logic rd, input logic [2:0] sel,
                      input logic [31:0] erd, input logic ec,
                      input logic enf, input logic ef, input string tag);
    corr_evt = c; unc_evt = u; unc_hdr_vld = hv; unc_hdr = h;
    rd_en = rd; rd_sel = sel;
    if (rd) begin exp_q.push_back(erd); tag_q.push_back(tag); end
    @(negedge clk);
    corr_evt = '0; unc_evt = '0; unc_hdr_vld = 1'b0; rd_en = 1'b0;
    n_cmp++;
    if ({rpt_corr, rpt_nonfatal, rpt_fatal} !== {ec, enf, ef}) begin
      n_bad++;
      $display("FAIL %s pulses c/nf/f act=%b%b%b exp=%b%b%b", tag,
               rpt_corr, rpt_nonfatal, rpt_fatal, ec, enf, ef);
    end
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] e, input string tag);
    step('0, '0, 1'b0, '0, 1'b1, sel, e, 1'b0, 1'b0, 1'b0, tag);
  endtask

  localparam logic [127:0] H1 = {32'h11110003, 32'h11110002, 32'h11110001, 32'h11110000};
  localparam logic [127:0] H2 = {32'h22220003, 32'h22220002, 32'h22220001, 32'h22220000};
  localparam logic [127:0] H3 = {32'h33330003, 32'h33330002, 32'h33330001, 32'h33330000};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(3'd0, 32'h0, "R5 reset corr");
    rd(3'd4, 32'h0, "R10 reset hdr");
    // correctable
    step(32'h1, '0, 0, '0, 0, 0, 0, 1, 0, 0, "R1 R7 first bit0");
    step(32'h1, '0, 0, '0, 0, 0, 0, 0, 0, 0, "R7 bit already set");
    step('1, '0, 0, '0, 0, 0, 0, 1, 0, 0, "R1 all new bits");
    rd(3'd0, 32'h000071C1, "R1 R3 corr positions");
    rd(3'd0, 32'h0, "R5 cleared by read");
    corr_en = '0;
    step(32'h40, '0, 0, '0, 0, 0, 0, 0, 0, 0, "R9 zero mask");
    rd(3'd0, 32'h40, "R4 sticky when disabled");
    corr_en = '1;
    // uncorrectable routing
    nonfatal_en = 32'h0000C000; fatal_en = 32'h00004010;
    step('0, 32'h4000, 0, '0, 0, 0, 0, 0, 0, 1, "R8 fatal priority");
    step('0, 32'h8000, 0, '0, 0, 0, 0, 0, 1, 0, "R8 nonfatal");
    step('0, 32'h10020, 0, '0, 0, 0, 0, 0, 0, 0, "R9 unenabled bit");
    rd(3'd1, 32'h0001C000, "R2 R3 unc status");
    step('0, 32'h10, 0, '0, 0, 0, 0, 0, 0, 1, "R2 bit4 fatal");
    // header log
    step('0, 32'h40000, 1, H1, 0, 0, 0, 0, 0, 0, "R10 capture");
    step('0, 32'h80000, 1, H2, 0, 0, 0, 0, 0, 0, "R10 frozen");
    for (int i = 0; i < 4; i++)
      rd(3'(4 + i), H1[32*i +: 32], "R10 R12 hdr dw");
    rd(3'd2, 32'h0, "R12 unused select");
    rd(3'd1, 32'h000C0010, "R5 unc read clear");
    step('0, 32'h100000, 1, H2, 0, 0, 0, 0, 0, 0, "R11 recapture");
    rd(3'd4, 32'h22220000, "R11 new header");
    // same-cycle event and clear
    step('0, 32'h1000, 1, H3, 1, 3'd1, 32'h00100000, 0, 0, 0, "R6 unc read+evt");
    rd(3'd7, 32'h33330003, "R6 hdr in clear cycle");
    rd(3'd1, 32'h00001000, "R6 unc evt kept");
    step(32'h40, '0, 0, '0, 0, 0, 0, 1, 0, 0, "R7 bit6");
    step(32'h80, '0, 0, '0, 1, 3'd0, 32'h40, 1, 0, 0, "R6 corr read+evt");
    rd(3'd0, 32'h80, "R6 corr evt kept");
    // partial mask, mixed classes
    corr_en = 32'h2000;
    step(32'h1, '0, 0, '0, 0, 0, 0, 0, 0, 0, "R9 bit not enabled");
    step(32'h2000, '0, 0, '0, 0, 0, 0, 1, 0, 0, "R7 enabled bit");
    step('0, 32'hC000, 0, '0, 0, 0, 0, 0, 1, 1, "R8 both classes");
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule